// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block sits between a DMA master and the memory system and turns 32-bit device virtual addresses into physical addresses. It walks a two-level table held in memory. The top ten bits of the page number select a word in the first-level table. That word gives the frame of a second-level table. The next ten bits select a word in that second-level table, and that word gives the frame of the target page. An eight-entry, fully associative cache of recent translations sits in front of the walker. A repeated page is answered on the cycle after the request is accepted, with no memory traffic.

Table words carry no valid flag. The walker never faults. Every word it fetches is used as a frame number. Software keeps unmapped regions pointing at harmless placeholder tables and pages. Two write-only controls configure the block. One holds the frame of the first-level table. The other flushes the translation cache when the value one is written to it. Changing the table base does not flush the cache, so software issues the flush afterwards.

Top module: `iova_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0, and the translation cache holds no entries.
- R2: The first fetch of a walk reads address {base_frame, 12'b0} + 4*iova[31:22], where base_frame is the 27-bit value last written with cfg_sel=0 (taken from cfg_wdata[26:0]).
- R3: The second fetch reads address {first_word, 12'b0} + 4*iova[21:12], where first_word is the 32-bit data returned by the first fetch.
- R4: After a walk, rsp_pa equals {second_word, iova[11:0]}, where second_word is the data returned by the second fetch. rsp_valid is high for one cycle, on the cycle after the second mem_rvalid.
- R5: A fetched word is used as a frame number whatever its value, zero included. No value makes the walk stop or fault.
- R6: A request whose page is in the cache gets rsp_valid on the cycle after it is accepted, with the cached frame and the request's offset, and it issues no memory read.
- R7: Each completed walk installs its page in the cache. Slots are replaced round robin across 8 slots, so the ninth new page evicts the first page cached.
- R8: A write with cfg_sel=1 and cfg_wdata equal to 1 empties the whole cache at once. A write with cfg_sel=1 and any other value leaves the cache unchanged.
- R9: A flush that arrives while a walk is in progress lets that walk finish with the correct address, but the result is not installed in the cache.
- R10: Writing the base (cfg_sel=0) does not flush the cache. Cached pages keep their old translation until a flush.
- R11: req_ready is 0 while a walk is in progress. mem_req stays high with a stable mem_addr until mem_rvalid, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_iova | input | 32 | Device virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: rsp_pa is valid |
| rsp_pa | output | 44 | Translated physical address |
| mem_req | output | 1 | Table-word read request, held until mem_rvalid |
| mem_addr | output | 44 | Byte address of the table word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table word (a frame number) |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0: table base frame, 1: cache flush |
| cfg_wdata | input | 32 | Control write data |

## Verification
The hardest case to reach from the ports is a flush that lands in the middle of a walk. The translation must still come out correct, and the result must not be kept in the cache. The bench drives this with a memory model of fixed latency. It issues a miss, waits a few cycles so the first table fetch is outstanding, and then writes the flush. It then checks that the answer is right and that asking for the same page again costs two fresh reads. Round-robin eviction is reached by filling all eight slots with distinct pages and adding a ninth. The check order is chosen so that checking a surviving page does not disturb the slot about to be tested.

// File: rtl/iova_walker.sv
module iova_walker #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_W  = 32,
  parameter int BASE_W = 27,
  parameter int TLB_N  = 8,
  parameter int PA_W   = PTE_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_iova,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_t;

  st_t               st;
  logic [BASE_W-1:0] base_q;
  logic [VA_W-1:0]   va_q;
  logic              drop;
  logic [VPN_W-1:0]  tlb_tag [TLB_N];
  logic [PTE_W-1:0]  tlb_pfn [TLB_N];
  logic [TLB_N-1:0]  tlb_vld;
  logic [PTR_W-1:0]  rr;

  logic              hit;
  logic [PTE_W-1:0]  hit_pfn;

  wire [VPN_W-1:0] req_vpn = req_iova[VA_W-1:OFF_W];
  wire [IDX_W-1:0] req_l1  = req_iova[VA_W-1:OFF_W+IDX_W];
  wire [IDX_W-1:0] q_l2    = va_q[OFF_W+IDX_W-1:OFF_W];
  wire             accept  = req_valid && req_ready;
  wire             flush   = cfg_we && cfg_sel && (cfg_wdata == 32'd1);
  wire             fill    = (st == S_L2) && mem_rvalid && !drop && !flush;

  wire [PA_W-1:0] l1_addr = PA_W'({base_q, {OFF_W{1'b0}}}) + PA_W'({req_l1, 2'b00});
  wire [PA_W-1:0] l2_addr = PA_W'({mem_rdata, {OFF_W{1'b0}}}) + PA_W'({q_l2, 2'b00});

  assign req_ready = (st == S_IDLE);

  always_comb begin
    hit = 1'b0;
    hit_pfn = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (tlb_vld[i] && tlb_tag[i] == req_vpn) begin
        hit = 1'b1;
        hit_pfn = tlb_pfn[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      va_q      <= '0;
      drop      <= 1'b0;
      tlb_vld   <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_we && !cfg_sel) base_q <= cfg_wdata[BASE_W-1:0];
      if (flush && st != S_IDLE) drop <= 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= {hit_pfn, req_iova[OFF_W-1:0]};
          end else begin
            va_q     <= req_iova;
            drop     <= 1'b0;
            mem_req  <= 1'b1;
            mem_addr <= l1_addr;
            st       <= S_L1;
          end
        end
        S_L1: if (mem_rvalid) begin
          mem_addr <= l2_addr;
          st       <= S_L2;
        end
        S_L2: if (mem_rvalid) begin
          mem_req   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_pa    <= {mem_rdata, va_q[OFF_W-1:0]};
          st        <= S_IDLE;
          if (fill) begin
            tlb_vld[rr] <= 1'b1;
            rr <= (rr == PTR_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (flush) tlb_vld <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tlb_tag[rr] <= va_q[VA_W-1:OFF_W];
      tlb_pfn[rr] <= mem_rdata;
    end
  end
endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk #(
  parameter int PA_W  = 44,
  parameter int TLB_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_rvalid,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic [31:0]      cfg_wdata,
  input logic [TLB_N-1:0] tlb_vld
);
  // R11
  walk_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R6
  accept_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_req));

  // R4
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rvalid || (req_valid && req_ready)));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && cfg_wdata == 32'd1) |=> (tlb_vld == '0));

  // R7
  single_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(tlb_vld) <= $countones($past(tlb_vld)) + 1));
endmodule

bind iova_walker iova_walker_chk #(.PA_W(PA_W), .TLB_N(TLB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .tlb_vld(tlb_vld)
);

// File: tb/iova_walker_test.sv
module iova_walker_test;
  localparam int MISS_CYC = 11;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_iova = 0;
  logic        rsp_valid;
  logic [43:0] rsp_pa;
  logic        mem_req;
  logic [43:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        cfg_we = 0;
  logic        cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;

  int vectors = 0;
  int errors = 0;
  logic [26:0] base_frame = 27'h0;

  always #2.5 clk = ~clk;

  iova_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_iova(req_iova), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata)
  );

  function automatic logic [31:0] word_at(logic [43:0] a);
    if (a[11:2] == 10'h3FF && a[43:12] == {5'b0, base_frame}) return 32'h0;
    return {a[33:14] ^ 20'hA5C3F, a[11:2] ^ a[23:14], 2'b01};
  endfunction

  function automatic logic [43:0] l1_addr_of(logic [31:0] va);
    return {5'b0, base_frame, 12'b0} + {32'b0, va[31:22], 2'b00};
  endfunction

  function automatic logic [43:0] l2_addr_of(logic [31:0] va);
    return {word_at(l1_addr_of(va)), 12'b0} + {32'b0, va[21:12], 2'b00};
  endfunction

  function automatic logic [43:0] pa_of(logic [31:0] va);
    return {word_at(l2_addr_of(va)), va[11:0]};
  endfunction

  int          rd_cnt;
  logic [43:0] last_a, prev_a, cur_a;
  logic        busy;
  int          lat;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 0; mem_rdata <= 0; busy <= 0; lat <= 0;
      rd_cnt <= 0; last_a <= 0; prev_a <= 0; cur_a <= 0;
    end else begin
      mem_rvalid <= 0;
      if (busy) begin
        if (lat == 0) begin
          mem_rvalid <= 1;
          mem_rdata  <= word_at(cur_a);
          busy       <= 0;
        end else lat <= lat - 1;
      end else if (mem_req && !mem_rvalid) begin
        busy <= 1; lat <= 2; cur_a <= mem_addr;
        prev_a <= last_a; last_a <= mem_addr; rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Sends one request and waits for the answer; is_hit selects the expected path.
  task automatic xlate(logic [31:0] va, logic [43:0] exp, bit is_hit, string req);
    int c0, cyc, rds;
    bit blocked_ok;
    c0 = rd_cnt; cyc = 0; blocked_ok = 1;
    @(negedge clk);
    req_iova = va; req_valid = 1;
    chk(req_ready == 1, "R11", "ready when idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; cyc = 1;
    while (!rsp_valid && cyc < 100) begin
      if (mem_req && req_ready) blocked_ok = 0;
      @(negedge clk); cyc++;
    end
    rds = rd_cnt - c0;
    chk(blocked_ok, "R11", "ready low during walk", blocked_ok, 1);
    chk(rsp_pa == exp, req, "physical address", rsp_pa, exp);
    if (is_hit) begin
      chk(rds == 0, "R6", "reads on hit", rds, 0);
      chk(cyc == 1, "R6", "hit latency", cyc, 1);
    end else begin
      chk(rds == 2, req, "reads on miss", rds, 2);
      chk(prev_a == l1_addr_of(va), "R2", "first fetch address", prev_a, l1_addr_of(va));
      chk(last_a == l2_addr_of(va), "R3", "second fetch address", last_a, l2_addr_of(va));
      chk(cyc == MISS_CYC, "R4", "walk latency", cyc, MISS_CYC);
    end
    @(negedge clk);
    chk(rsp_valid == 0, "R4", "single-cycle response", rsp_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(mem_req == 0, "R1", "mem_req", mem_req, 0);
  endtask

  task automatic t_basic;
    base_frame = 27'h12_3456;
    cfg_write(0, {5'b0, base_frame});
    xlate(32'h0040_1ABC, pa_of(32'h0040_1ABC), 0, "R1");
    xlate(32'h0040_1FF0, pa_of(32'h0040_1FF0), 1, "R6");
    xlate(32'hABCD_E123, pa_of(32'hABCD_E123), 0, "R4");
    xlate(32'hABCD_E000, pa_of(32'hABCD_E000), 1, "R6");
  endtask

  task automatic t_zero_word;
    xlate(32'hFFC0_1234, pa_of(32'hFFC0_1234), 0, "R5");
    chk(last_a == 44'h004, "R5", "zero frame used", last_a, 44'h004);
  endtask

  task automatic t_flush_value;
    cfg_write(1, 32'd2);
    xlate(32'hABCD_E777, pa_of(32'hABCD_E777), 1, "R8");
    cfg_write(1, 32'd1);
    xlate(32'hABCD_E777, pa_of(32'hABCD_E777), 0, "R8");
  endtask

  task automatic t_round_robin;
    cfg_write(1, 32'd1);
    for (int i = 0; i < 8; i++) xlate(32'h1000_0000 + i * 32'h0040_1000, pa_of(32'h1000_0000 + i * 32'h0040_1000), 0, "R7");
    for (int i = 0; i < 8; i++) xlate(32'h1000_0004 + i * 32'h0040_1000, pa_of(32'h1000_0004 + i * 32'h0040_1000), 1, "R7");
    xlate(32'h2000_0000, pa_of(32'h2000_0000), 0, "R7");
    xlate(32'h1040_1000, pa_of(32'h1040_1000), 1, "R7");
    xlate(32'h1000_0000, pa_of(32'h1000_0000), 0, "R7");
    xlate(32'h1080_2000, pa_of(32'h1080_2000), 1, "R7");
  endtask

  task automatic t_flush_mid_walk;
    logic [31:0] va;
    logic [43:0] exp;
    int cyc;
    va = 32'h3333_3555; exp = pa_of(va); cyc = 0;
    @(negedge clk);
    req_iova = va; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'd1;
    @(negedge clk);
    cfg_we = 0;
    while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk(rsp_valid == 1, "R9", "walk completes", rsp_valid, 1);
    chk(rsp_pa == exp, "R9", "address after flush", rsp_pa, exp);
    xlate(va, exp, 0, "R9");
    xlate(va, exp, 1, "R9");
  endtask

  task automatic t_base_change;
    logic [31:0] va;
    logic [43:0] old_pa;
    va = 32'h0555_5ABC;
    xlate(va, pa_of(va), 0, "R10");
    old_pa = pa_of(va);
    base_frame = 27'h7_0F0F;
    cfg_write(0, {5'b0, base_frame});
    xlate(va, old_pa, 1, "R10");
    cfg_write(1, 32'd1);
    xlate(va, pa_of(va), 0, "R10");
    chk(pa_of(va) != old_pa, "R10", "new base differs", pa_of(va), old_pa);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_basic();
    t_zero_word();
    t_flush_value();
    t_round_robin();
    t_flush_mid_walk();
    t_base_change();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule